// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input frequency by a programmable ratio N. It works with an external dual-modulus prescaler that divides by 16 or by 17. The block's counters are clocked by the prescaler output. A mode-select output tells the prescaler which modulus to use in each prescaler cycle. An 18-bit ratio word sets N in two parts: a main count B and a swallow count A, so that N = 16·B + A. One output pulse is produced per N input cycles. That pulse goes to a phase comparator, and a monitor copy is brought out for observation.

In each output period, the swallow counter keeps the prescaler at divide-by-17 for the first A prescaler cycles. The prescaler then divides by 16 until the main counter has run through all B cycles. Both counters reload from the ratio word only at the end of a period, so a ratio change never produces a short or mixed period. A low run input puts the divider in standby. On return to run, the divider starts from a fresh reload, so the first period after standby is complete.

Top module: `pls_divider`

## Requirements
- R1: The divide ratio is N = 16·B + A input cycles per output pulse, where B = ratio_word[17:4] and A = ratio_word[3:0].
- R2: mod_sel is high (divide-by-17) for the first A prescaler cycles of each period and low after that. It is always low in the cycle where div_pulse is high.
- R3: A main count B below 17 is treated as 17, so N = 272 + A for any B from 0 to 16.
- R4: div_pulse is high for exactly one prescaler cycle per period and is never high in two consecutive cycles.
- R5: mon_pulse is always equal to div_pulse.
- R6: A ratio word change made partway through a period does not alter that period. The new ratio applies from the next period.
- R7: When run_en is low, div_pulse and mod_sel are low from the second prescaler clock edge onward.
- R8: After run_en goes high again, the first div_pulse begins on the B-th prescaler clock edge, counting the first edge that samples run_en high as edge 1.
- R9: While rst_n is low, div_pulse, mon_pulse and mod_sel are low, and the divider is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: divide; low: standby |
| ratio_word | input | 18 | {B[13:0], A[3:0]} ratio setting |
| mod_sel | output | 1 | 1 requests prescaler divide-by-17, 0 divide-by-16 |
| div_pulse | output | 1 | One-cycle pulse per output period, to the comparator |
| mon_pulse | output | 1 | Monitor copy of div_pulse |

## Verification
The assertions assume that run_en and ratio_word are synchronous to clk_pre, and that the main count is at least 16, so that A never exceeds B. The clamp ensures the second condition for every ratio word. The stimulus changes inputs only on falling edges of the fast input clock. It draws random ratios with B between 17 and 200 and adds directed low-B values to exercise the clamp. A behavioural divide-by-16/17 prescaler in the bench turns mod_sel into the block's clock. Every expected period is counted in fast input cycles between pulses.

// File: rtl/pls_div_pkg.sv
package pls_div_pkg;

   typedef enum logic {
      PH_STANDBY = 1'b0,
      PH_ACTIVE  = 1'b1
   } pls_phase_e;

endpackage

// File: rtl/pls_ratio_decode.sv
module pls_ratio_decode #(
   parameter int MAIN_W   = 14,
   parameter int SWAL_W   = 4,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [MAIN_W+SWAL_W-1:0] ratio_word,
   output logic [MAIN_W-1:0]        main_load,
   output logic [SWAL_W-1:0]        swal_load
);
   localparam int RATIO_W = MAIN_W + SWAL_W;
   localparam int B_MIN   = (1 << SWAL_W) + 1;

   logic [MAIN_W-1:0] b_raw;
   logic [MAIN_W-1:0] b_eff;

   assign b_raw     = ratio_word[RATIO_W-1:SWAL_W];
   assign swal_load = ratio_word[SWAL_W-1:0];

   generate
      if (CLAMP_EN) begin : g_clamp
         // R3: raise short main counts to the legal floor
         assign b_eff = (b_raw < MAIN_W'(B_MIN)) ? MAIN_W'(B_MIN) : b_raw;
      end else begin : g_pass
         assign b_eff = b_raw;
      end
   endgenerate

   // main counter runs B_eff-1 .. 0, i.e. B_eff prescaler cycles
   assign main_load = b_eff - MAIN_W'(1);

   initial begin
      assert (SWAL_W >= 1) else $error("SWAL_W must be at least 1");
      assert (MAIN_W > SWAL_W) else $error("MAIN_W must exceed SWAL_W");
   end
endmodule

// File: rtl/pls_main_cnt.sv
module pls_main_cnt #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         en,
   input  logic [W-1:0] load_val,
   output logic         term
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (en) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign term = (cnt_q == '0);

   // R3: a reload always starts a period of many cycles, so the terminal state is left
   p_reload_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !term);
endmodule

// File: rtl/pls_swallow_cnt.sv
module pls_swallow_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         en,
   input  logic [W-1:0] load_val,
   output logic         busy
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (en && (cnt_q != '0)) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign busy = (cnt_q != '0);

   // R2: once the swallow phase ends it stays ended until the next reload
   p_swallow_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> !busy);
endmodule

// File: rtl/pls_divider.sv
module pls_divider #(
   parameter int MAIN_W   = 14,
   parameter int SWAL_W   = 4,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic                      clk_pre,
   input  logic                      rst_n,
   input  logic                      run_en,
   input  logic [MAIN_W+SWAL_W-1:0]  ratio_word,
   output logic                      mod_sel,
   output logic                      div_pulse,
   output logic                      mon_pulse
);
   import pls_div_pkg::*;

   pls_phase_e        phase_q;
   logic [MAIN_W-1:0] main_load;
   logic [SWAL_W-1:0] swal_load;
   logic              reload;
   logic              step;
   logic              main_term;
   logic              swal_busy;
   logic              active;

   pls_ratio_decode #(
      .MAIN_W  (MAIN_W),
      .SWAL_W  (SWAL_W),
      .CLAMP_EN(CLAMP_EN)
   ) u_decode (
      .ratio_word(ratio_word),
      .main_load (main_load),
      .swal_load (swal_load)
   );

   always_ff @(posedge clk_pre or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_STANDBY;
      end else begin
         phase_q <= run_en ? PH_ACTIVE : PH_STANDBY;
      end
   end

   assign active = (phase_q == PH_ACTIVE);
   // standby, a run request and the period end all force a fresh load (R6, R8)
   assign reload = !active || !run_en || main_term;
   assign step   = active && run_en;

   pls_main_cnt #(.W(MAIN_W)) u_main (
      .clk     (clk_pre),
      .rst_n   (rst_n),
      .load    (reload),
      .en      (step),
      .load_val(main_load),
      .term    (main_term)
   );

   pls_swallow_cnt #(.W(SWAL_W)) u_swal (
      .clk     (clk_pre),
      .rst_n   (rst_n),
      .load    (reload),
      .en      (step),
      .load_val(swal_load),
      .busy    (swal_busy)
   );

   assign mod_sel   = active && swal_busy;
   assign div_pulse = active && main_term;
   assign mon_pulse = div_pulse;

   // R7: standby sampled on the previous edge silences both outputs
   p_idle_quiet_r7: assert property (@(posedge clk_pre) disable iff (!rst_n)
      !$past(run_en) |-> (!div_pulse && !mod_sel));

   // R4: the output pulse lasts a single prescaler cycle
   p_single_pulse_r4: assert property (@(posedge clk_pre) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R2: the swallow phase has finished before the main count expires
   p_mod_low_at_term_r2: assert property (@(posedge clk_pre) disable iff (!rst_n)
      div_pulse |-> !mod_sel);
endmodule

// File: tb/pls_divider_bench.sv
module pls_divider_bench;
   logic        fin = 1'b0;
   logic        clk_pre = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [17:0] ratio_word = {14'd20, 4'd3};
   logic        mod_sel, div_pulse, mon_pulse;

   int unsigned checks = 0;
   int unsigned fails = 0;
   int unsigned fcnt = 0;
   int unsigned last_rise = 0;
   int unsigned last_delta = 0;
   int unsigned rises = 0;
   int unsigned pedges = 0;
   logic        pulse_prev = 1'b0;
   logic [4:0]  pc = '0;
   bit          done = 1'b0;

   pls_divider u_pls_divider (
      .clk_pre   (clk_pre),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .ratio_word(ratio_word),
      .mod_sel   (mod_sel),
      .div_pulse (div_pulse),
      .mon_pulse (mon_pulse)
   );

   always #2.5 fin = ~fin;

   // behavioural dual-modulus prescaler: 16 or 17 fin cycles per clk_pre edge
   always @(posedge fin) begin
      fcnt <= fcnt + 1;
      if (pc == (mod_sel ? 5'd16 : 5'd15)) begin
         pc      <= '0;
         clk_pre <= 1'b1;
      end else begin
         pc      <= pc + 5'd1;
         clk_pre <= 1'b0;
      end
   end

   always @(posedge clk_pre) pedges <= pedges + 1;

   always @(negedge fin) begin
      if (div_pulse && !pulse_prev) begin
         last_delta = fcnt - last_rise;
         last_rise  = fcnt;
         rises      = rises + 1;
      end
      pulse_prev = div_pulse;
   end

   function automatic int unsigned exp_b(input logic [17:0] r);
      int unsigned b = r[17:4];
      return (b < 17) ? 17 : b;
   endfunction

   function automatic int unsigned exp_n(input logic [17:0] r);
      return 16 * exp_b(r) + r[3:0];
   endfunction

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_rise();
      int unsigned c = rises;
      wait (rises != c);
   endtask

   task automatic wait_pedges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk_pre);
      @(negedge fin);
   endtask

   logic [17:0] cur, nxt;
   int unsigned p0;
   int unsigned bad;

   initial begin
      void'($urandom(32'd4242));
      // R9: reset state
      repeat (40) @(negedge fin);
      check("R9 mod_sel in reset", mod_sel, 0);
      check("R9 div_pulse in reset", div_pulse, 0);
      check("R9 mon_pulse in reset", mon_pulse, 0);
      rst_n  = 1'b1;
      run_en = 1'b1;
      wait_rise();
      // directed: smallest legal and clamped ratios
      cur = {14'd17, 4'd0};
      ratio_word = cur;
      wait_rise();
      check("R1 N for B=17 A=0", last_delta, 272);
      cur = {14'd17, 4'd15};
      ratio_word = cur;
      wait_rise();
      check("R1 N for B=17 A=15", last_delta, 287);
      cur = {14'd3, 4'd5};
      ratio_word = cur;
      wait_rise();
      check("R3 clamp B=3 A=5", last_delta, exp_n(cur));
      cur = {14'd0, 4'd9};
      ratio_word = cur;
      wait_rise();
      check("R3 clamp B=0 A=9", last_delta, exp_n(cur));
      // random ratios
      for (int i = 0; i < 12; i++) begin
         cur = {14'(17 + ($urandom % 184)), 4'($urandom % 16)};
         ratio_word = cur;
         wait_rise();
         check("R1 random ratio", last_delta, exp_n(cur));
         check("R5 monitor copy", mon_pulse, div_pulse);
      end
      // R6: a change partway through a period waits for the boundary
      wait_pedges(5);
      nxt = {14'd40, 4'd7};
      ratio_word = nxt;
      wait_rise();
      check("R6 old ratio kept mid-period", last_delta, exp_n(cur));
      wait_rise();
      check("R6 new ratio after boundary", last_delta, exp_n(nxt));
      // R4: pulse width is one prescaler cycle
      wait_pedges(1);
      check("R4 pulse drops after one cycle", div_pulse, 0);
      // R2: mod_sel pattern across a period with A=7, B=40
      wait_rise();
      bad = 0;
      for (int k = 1; k <= 12; k++) begin
         wait_pedges(1);
         if (mod_sel != (k <= 7)) bad++;
      end
      check("R2 mod_sel high for first A cycles", bad, 0);
      // R7: standby
      run_en = 1'b0;
      ratio_word = {14'd25, 4'd2};
      wait_pedges(2);
      bad = 0;
      for (int k = 0; k < 600; k++) begin
         @(negedge fin);
         if (div_pulse || mod_sel || mon_pulse) bad++;
      end
      check("R7 outputs quiet in standby", bad, 0);
      // R8: complete first period after wake-up
      cur = ratio_word;
      p0 = pedges;
      run_en = 1'b1;
      wait_rise();
      check("R8 first pulse edge count", pedges - p0, exp_b(cur));
      wait_rise();
      check("R8 period after wake", last_delta, exp_n(cur));
      done = 1'b1;
   end

   initial begin
      wait (done || fcnt > 190000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule